// File: doc/BRIEF.md
# Byte-Stream Frame Aligner

This block locates and follows the boundaries of fixed-length frames carried in a byte-wide stream. Each frame opens with a six-byte alignment word: three bytes of 8'hF6 followed by three bytes of 8'h28, at frame positions 1 to 6. One byte is taken on each clock where `byte_valid` is high. Cycles where `byte_valid` is low are gaps and change nothing.

Acquisition uses a four-byte window. When the stream shows F6 F6 28 28 (positions 2 to 5), a candidate position is armed. The candidate is confirmed only when the same window appears at the same place exactly one frame later. Once in frame, a three-byte window (F6 28 28 at positions 3 to 5) is checked once per frame. Five misses in a row drop the block back to the searching state. The byte position counter keeps running while out of frame, so the presumed frame start is held and not discarded.

The frame length is a parameter. It is nominally 16320 bytes and can be shortened for simulation. Downstream logic uses `frame_start` to mark byte 1, `byte_pos` to place each byte inside the frame, and `in_frame` as the lock flag.

Top module: `frame_aligner`

## Requirements
- R1: After reset, `in_frame` is 0, `frame_start` is 0 and `byte_pos` equals FRAME_LEN, so the first accepted byte is counted as position 1.
- R2: A cycle with `byte_valid` low changes none of `byte_pos` or `in_frame`, and `frame_start` is 0 in the cycle that follows it.
- R3: While out of frame with no candidate armed, the four accepted bytes 8'hF6, 8'hF6, 8'h28, 8'h28 (the last one the current byte) arm a candidate and set `byte_pos` to 5 for that byte. `in_frame` stays 0. Position 2 of the word takes part in this match.
- R4: An armed candidate moves the block in frame only when the same four-byte window ends at position 5 of the next frame. Otherwise the candidate is dropped and the search resumes from the following bytes.
- R5: In frame, the only bytes examined are positions 3, 4 and 5, which must be 8'hF6, 8'h28, 8'h28. Corrupting positions 1, 2 or 6 has no effect.
- R6: `in_frame` falls only after the in-frame check fails in MISS_LIMIT (5) consecutive frames. A single correct frame clears the miss count. The fall occurs on the byte at position 5.
- R7: `byte_pos` counts 1 to FRAME_LEN and wraps to 1 on each accepted byte. It is reloaded only when a candidate is armed, so it keeps running through loss of frame.
- R8: `frame_start` is high for exactly one cycle, after the byte at position 1 has been accepted while in frame. In that cycle `byte_pos` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Byte qualifier; `byte_in` is taken when high |
| byte_in | input | 8 | Stream byte |
| frame_start | output | 1 | One-cycle pulse marking frame byte 1 while in frame |
| in_frame | output | 1 | Frame lock flag |
| byte_pos | output | $clog2(FRAME_LEN+1) | Position (1..FRAME_LEN) of the last accepted byte |

## Verification
The assertions assume that `byte_valid` and `byte_in` are stable, known values on every sampling edge after reset. They also assume FRAME_LEN is at least 6, so that the alignment word fits inside one frame. The stimulus changes inputs only on the falling clock edge. It runs with a 24-byte frame, and its filler bytes never contain 8'hF6 or 8'h28, so the alignment word appears only where the bench places it. Gaps with `byte_valid` low are inserted inside frames. This keeps the counter and flag checks honest across idle cycles without leaving the assumed input domain.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam logic [7:0] SYNC_HI  = 8'hF6;
    localparam logic [7:0] SYNC_LO  = 8'h28;
    localparam int         ACQ_LEN  = 4;
    localparam int         CHK_LEN  = 3;
    localparam int         HIST_LEN = ACQ_LEN - 1;
    localparam int         MARK_POS = 5;
    localparam logic [ACQ_LEN*8-1:0] ACQ_WORD = {SYNC_HI, SYNC_HI, SYNC_LO, SYNC_LO};
    localparam logic [CHK_LEN*8-1:0] CHK_WORD = {SYNC_HI, SYNC_LO, SYNC_LO};

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } sync_st_e;
endpackage

// File: rtl/fa_window.sv
module fa_window
    import fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       acq_hit,
    output logic       chk_hit
);
    localparam int HW = HIST_LEN * 8;

    logic [HW-1:0]        hist_d, hist_q;
    logic [ACQ_LEN*8-1:0] win;
    logic [ACQ_LEN-1:0]   byte_eq;

    assign win = {hist_q, byte_in};

    for (genvar g = 0; g < ACQ_LEN; g++) begin : g_cmp
        assign byte_eq[g] = (win[g*8 +: 8] == ACQ_WORD[g*8 +: 8]);
    end

    // acquisition needs every byte of the window; the in-frame check
    // compares its own, shorter pattern over the newest bytes
    assign acq_hit = &byte_eq;
    assign chk_hit = (win[CHK_LEN*8-1:0] == CHK_WORD);

    always_comb begin
        hist_d = hist_q;
        if (byte_valid) begin
            hist_d = {hist_q[HW-9:0], byte_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/fa_poscnt.sv
module fa_poscnt
    import fa_pkg::*;
#(
    parameter int FRAME_LEN = 16320,
    parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             load_mark,
    output logic [POS_W-1:0] pos_q,
    output logic             at_wrap,
    output logic             at_mark
);
    localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0] FIRST = POS_W'(1);
    localparam logic [POS_W-1:0] MARK  = POS_W'(MARK_POS);

    logic [POS_W-1:0] pos_d;

    assign at_wrap = (pos_q == LAST);
    assign at_mark = (pos_q == MARK - FIRST);

    always_comb begin
        pos_d = pos_q;
        if (advance) begin
            if (load_mark) begin
                pos_d = MARK;
            end else if (at_wrap) begin
                pos_d = FIRST;
            end else begin
                pos_d = pos_q + FIRST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST;
        end else begin
            pos_q <= pos_d;
        end
    end
endmodule

// File: rtl/fa_sync.sv
module fa_sync
    import fa_pkg::*;
#(
    parameter int MISS_LIMIT = 5,
    parameter int MISS_W     = $clog2(MISS_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_valid,
    input  logic acq_hit,
    input  logic chk_hit,
    input  logic at_mark,
    input  logic at_wrap,
    output logic load_mark,
    output logic frame_start,
    output logic in_frame
);
    localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);
    localparam logic [MISS_W-1:0] MISS_ONE = MISS_W'(1);

    typedef struct packed {
        sync_st_e          st;
        logic              armed;
        logic [MISS_W-1:0] miss;
        logic              fs;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.fs    = 1'b0;
        load_mark = 1'b0;
        if (byte_valid) begin
            unique case (r_q.st)
                ST_SEARCH: begin
                    if (!r_q.armed) begin
                        if (acq_hit) begin
                            r_d.armed = 1'b1;
                            load_mark = 1'b1;
                        end
                    end else if (at_mark) begin
                        r_d.armed = 1'b0;
                        if (acq_hit) begin
                            r_d.st   = ST_LOCKED;
                            r_d.miss = '0;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_mark) begin
                        if (chk_hit) begin
                            r_d.miss = '0;
                        end else if (r_q.miss == MISS_TOP) begin
                            r_d.st   = ST_SEARCH;
                            r_d.miss = '0;
                        end else begin
                            r_d.miss = r_q.miss + MISS_ONE;
                        end
                    end
                end
                default: r_d = r_q;
            endcase
            r_d.fs = (r_d.st == ST_LOCKED) && at_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SEARCH, armed: 1'b0, miss: '0, fs: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_start = r_q.fs;
    assign in_frame    = (r_q.st == ST_LOCKED);
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import fa_pkg::*;
#(
    parameter int FRAME_LEN  = 16320,
    parameter int MISS_LIMIT = 5,
    localparam int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    output logic             frame_start,
    output logic             in_frame,
    output logic [POS_W-1:0] byte_pos
);
    logic acq_hit, chk_hit;
    logic at_mark, at_wrap, load_mark;

    fa_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .acq_hit    (acq_hit),
        .chk_hit    (chk_hit)
    );

    fa_poscnt #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (byte_valid),
        .load_mark (load_mark),
        .pos_q     (byte_pos),
        .at_wrap   (at_wrap),
        .at_mark   (at_mark)
    );

    fa_sync #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .acq_hit     (acq_hit),
        .chk_hit     (chk_hit),
        .at_mark     (at_mark),
        .at_wrap     (at_wrap),
        .load_mark   (load_mark),
        .frame_start (frame_start),
        .in_frame    (in_frame)
    );
endmodule

// File: rtl/fa_checker.sv
module fa_checker
    import fa_pkg::*;
#(
    parameter int FRAME_LEN = 16320,
    parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             frame_start,
    input logic             in_frame,
    input logic [POS_W-1:0] byte_pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN);
    localparam logic [POS_W-1:0] ONE  = POS_W'(1);
    localparam logic [POS_W-1:0] MARK = POS_W'(MARK_POS);

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_pos >= ONE) && (byte_pos <= LAST));

    assert_locked_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && in_frame) |=>
            (byte_pos == (($past(byte_pos) == LAST) ? ONE : $past(byte_pos) + ONE)));

    assert_gap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> ($stable(byte_pos) && $stable(in_frame) && !frame_start));

    assert_start_at_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (byte_pos == ONE) && in_frame);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_lock_at_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (byte_pos == MARK));

    assert_loss_at_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> (byte_pos == MARK));
endmodule

bind frame_aligner fa_checker #(
    .FRAME_LEN (FRAME_LEN)
) u_fa_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .frame_start (frame_start),
    .in_frame    (in_frame),
    .byte_pos    (byte_pos)
);

// File: tb/sim_frame_aligner.sv
module sim_frame_aligner;
    localparam int L     = 24;
    localparam int POS_W = $clog2(L + 1);
    localparam int NROWS = 14;

    // row: [4:3] frame kind, [1] in_frame expected after frame, [0] frame_start expected at byte 1
    // kinds: 0 clean, 1 position 4 corrupted, 2 positions 1,2,6 corrupted, 3 positions 1,6 corrupted
    localparam logic [4:0] TAB [NROWS] = '{
        5'b00_0_0_0, 5'b00_0_1_0, 5'b01_0_1_1, 5'b01_0_1_1,
        5'b00_0_1_1, 5'b10_0_1_1, 5'b01_0_1_1, 5'b01_0_1_1,
        5'b01_0_1_1, 5'b01_0_1_1, 5'b01_0_0_1, 5'b00_0_0_0,
        5'b00_0_1_0, 5'b00_0_1_1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_in = 8'h00;
    logic             frame_start;
    logic             in_frame;
    logic [POS_W-1:0] byte_pos;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    frame_aligner #(.FRAME_LEN(L)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .byte_in     (byte_in),
        .frame_start (frame_start),
        .in_frame    (in_frame),
        .byte_pos    (byte_pos)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input int i, input int kind);
        logic [7:0] b;
        if (i <= 3)      b = 8'hF6;
        else if (i <= 6) b = 8'h28;
        else             b = 8'(8'h40 + i);
        if (kind == 1 && i == 4) b = 8'h00;
        if (kind == 2 && (i == 1 || i == 2 || i == 6)) b = 8'h00;
        if (kind == 3 && (i == 1 || i == 6)) b = 8'h00;
        return b;
    endfunction

    task automatic put(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_frame == 1'b0, "R1 in_frame after reset", in_frame, 0);
        check(frame_start == 1'b0, "R1 frame_start after reset", frame_start, 0);
        check(byte_pos == POS_W'(L), "R1 byte_pos after reset", byte_pos, L);
    endtask

    task automatic send_frame(input int kind, input int exp_fs, input bit full);
        for (int i = 1; i <= L; i++) begin
            put(hdr(i, kind));
            if (full && i == 1) begin
                check(frame_start == exp_fs[0], "R8 frame_start at byte 1", frame_start, exp_fs);
                if (exp_fs != 0)
                    check(byte_pos == 1, "R8 byte_pos with frame_start", byte_pos, 1);
            end else if (full && frame_start) begin
                check(1'b0, "R8 stray frame_start", i, 1);
            end
            if (full && i == 10) begin
                logic [POS_W-1:0] p;
                logic f;
                p = byte_pos;
                f = in_frame;
                repeat (2) @(negedge clk);
                check(byte_pos == p && in_frame == f && !frame_start,
                      "R2 gap holds state", byte_pos, p);
            end
        end
        if (full)
            check(byte_pos == POS_W'(L), "R7 position at frame end", byte_pos, L);
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: acquisition, confirmation, miss counting, loss and reacquisition
        for (int r = 0; r < NROWS; r++) begin
            send_frame(int'(TAB[r][4:3]), int'(TAB[r][0]), 1'b1);
            check(in_frame == TAB[r][1], $sformatf("R4 R5 R6 in_frame after row %0d", r),
                  in_frame, TAB[r][1]);
        end

        // R3: acquisition at an arbitrary offset reloads the position to 5
        do_reset();
        for (int i = 0; i < 7; i++) put(8'h70);
        for (int i = 1; i <= 5; i++) put(hdr(i, 0));
        check(byte_pos == 5, "R3 position reloaded on match", byte_pos, 5);
        check(in_frame == 1'b0, "R3 not in frame after first match", in_frame, 0);
        for (int i = 6; i <= L; i++) put(hdr(i, 0));
        send_frame(0, 0, 1'b0);
        check(in_frame == 1'b1, "R4 locked after confirmation", in_frame, 1);

        // R4: failed confirmation drops the candidate; a later match re-arms
        do_reset();
        send_frame(0, 0, 1'b0);
        send_frame(1, 0, 1'b0);
        check(in_frame == 1'b0, "R4 failed confirmation stays out", in_frame, 0);
        send_frame(0, 0, 1'b0);
        check(in_frame == 1'b0, "R4 re-armed, not yet locked", in_frame, 0);
        send_frame(0, 0, 1'b0);
        check(in_frame == 1'b1, "R4 locked after re-arm", in_frame, 1);

        // R3: position 2 is part of the acquisition window
        do_reset();
        for (int k = 0; k < 3; k++) send_frame(2, 0, 1'b0);
        check(in_frame == 1'b0, "R3 byte 2 corrupt blocks lock", in_frame, 0);
        // R3 R5: positions 1 and 6 do not matter for acquisition
        do_reset();
        send_frame(3, 0, 1'b0);
        send_frame(3, 0, 1'b0);
        check(in_frame == 1'b1, "R3 lock with bytes 1 and 6 corrupt", in_frame, 1);

        // R7: counter keeps running while out of frame after loss
        for (int k = 0; k < 5; k++) send_frame(1, 0, 1'b0);
        check(in_frame == 1'b0, "R6 loss after five misses", in_frame, 0);
        for (int i = 1; i <= 3; i++) put(8'h70);
        check(byte_pos == 3, "R7 counter runs in search state", byte_pos, 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule